// File: doc/BRIEF.md
# Frame-Locked Pulse Clock Generator

This block produces switching clocks that stay phase-locked to a time-multiplexed sampling frame. A slot counter moves forward once for every sample tick and wraps after 128 slots. One full pass of the counter is one frame, and each multiplexed channel is sampled once per frame. Three pulse lanes each hold a programmable pulse count n. A lane places exactly n one-slot pulses in every frame, spread as evenly as one-slot resolution allows, and repeats the same pattern in every frame. Because of this, any integer count from 1 to 64 stays locked to the frame, and not only the power-of-two divisions.

A separate two-phase non-overlapping clock completes a fixed number of cycles per frame (four by default). Each phase change is preceded by a programmable dead time, counted in fast-clock cycles, during which both phases are low. Software writes the lane counts and the dead time through a one-cycle write strobe with a select field. A new count is held back until the next frame start, so no frame ever mixes two pulse counts.

Top module: `frame_pulse_clkgen`

## Requirements
- R1: The slot counter advances once per cycle with `tick_en` high and wraps after 128 ticks. `frame_strobe` goes high at the tick taken in slot 0 and falls at the following tick, so it is high for one slot interval per 128 ticks.
- R2: With active count n, a lane's output in slot s (s = 0 is the slot interval in which `frame_strobe` is high) is high exactly when floor((s+1)·n/128) > floor(s·n/128). Each frame therefore holds exactly n pulses, each one slot wide.
- R3: While a lane's count is not rewritten, every frame carries the identical pulse pattern.
- R4: When n is a power of two, the pulses are uniformly spaced 128/n slots apart.
- R5: A count of 0 holds the lane output low. A written value above 64 is stored as 64.
- R6: `cfg_sel` values 0, 1 and 2 select lanes 0, 1 and 2. A write to one lane leaves the patterns of the other lanes unchanged.
- R7: A count written during a frame takes effect at the next slot-0 tick. The frame in progress completes with the old count.
- R8: `phi1` and `phi2` are never high together. Each one rises 4 times per frame. `phi1` occupies the first 16-slot half of each 32-slot window, and `phi2` occupies the second half.
- R9: `cfg_sel` = 3 writes the dead time d from `cfg_data[3:0]`, and a value of 0 is stored as 1. After the tick that starts a half-window, both phases are low for exactly d fast-clock cycles before the selected phase rises.
- R10: While reset is asserted, all outputs are low. After reset, all counts are 0, the dead time is 1 and the slot counter is at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Sample-clock tick, one fast cycle wide |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0..2 lane count, 3 dead time |
| cfg_data | input | 7 | Write value |
| pulse_clk | output | 3 | Frame-locked pulse outputs, one per lane |
| phi1 | output | 1 | First non-overlapping phase |
| phi2 | output | 1 | Second non-overlapping phase |
| frame_strobe | output | 1 | High for the slot interval that follows the slot-0 tick |

## Verification
The assertions check the following on every cycle:
- the slot step and wrap;
- the alignment of the strobe with slot 1 of the counter;
- the per-frame pulse total of each lane against its active count;
- the quiet output of a zero count;
- that the active count holds between frame starts;
- the saturation of stored counts;
- phase non-overlap, and that both phases are low after each half-window boundary.

Some behaviours can only be shown by the bench scenarios. These are the exact slot position of every pulse, frame-to-frame repetition, the deferral of a write made in mid-frame, lane independence, and the measured dead-time length and phase-rise counts for several dead-time settings, including a written 0.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int FRAME_SLOTS      = 128;
  localparam int NUM_LANES        = 3;
  localparam int CNT_W            = 7;
  localparam int MAX_COUNT        = 64;
  localparam int PHASES_PER_FRAME = 4;
  localparam int DEAD_W           = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ONE  = 2'd1,
    PH_TWO  = 2'd2
  } ph_state_e;
endpackage

// File: rtl/fpc_rst_sync.sv
module fpc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/fpc_slot_counter.sv
module fpc_slot_counter #(
  parameter int SLOTS  = fpc_pkg::FRAME_SLOTS,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [SLOT_W-1:0] slot_o,
  output logic              frame_start_o,
  output logic              strobe_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] ONE_SLOT  = SLOT_W'(1);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              strobe_q, strobe_d;
  logic              at_zero;

  always_comb begin
    at_zero  = (slot_q == '0);
    slot_d   = slot_q;
    strobe_d = strobe_q;
    if (tick) begin
      slot_d   = (slot_q == LAST_SLOT) ? '0 : slot_q + ONE_SLOT;
      strobe_d = at_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      slot_q   <= slot_d;
      strobe_q <= strobe_d;
    end
  end

  assign slot_o        = slot_q;
  assign frame_start_o = tick && at_zero;
  assign strobe_o      = strobe_q;

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (slot_q == (($past(slot_q) == LAST_SLOT) ? '0 : $past(slot_q) + ONE_SLOT)));

  // R1
  strobe_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> (slot_q == ONE_SLOT));
endmodule

// File: rtl/fpc_pulse_lane.sv
module fpc_pulse_lane #(
  parameter int SLOTS     = fpc_pkg::FRAME_SLOTS,
  parameter int CNT_W     = fpc_pkg::CNT_W,
  parameter int MAX_COUNT = fpc_pkg::MAX_COUNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             frame_start,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_cnt,
  output logic             pulse_o
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int SUM_W  = ((SLOT_W > CNT_W) ? SLOT_W : CNT_W) + 1;
  localparam logic [SUM_W-1:0] SLOTS_S = SUM_W'(SLOTS);
  localparam logic [CNT_W-1:0] MAX_V   = CNT_W'(MAX_COUNT);

  logic [CNT_W-1:0]  pend_q, pend_d;
  logic [CNT_W-1:0]  act_q, act_d;
  logic [CNT_W-1:0]  n_eff;
  logic [SLOT_W-1:0] acc_q, acc_d, acc_base;
  logic [SUM_W-1:0]  sum;
  logic              carry;
  logic              pulse_q, pulse_d;

  // staging register: saturate on write
  always_comb begin
    pend_d = pend_q;
    if (wr_en) begin
      pend_d = (wr_cnt > MAX_V) ? MAX_V : wr_cnt;
    end
  end

  // phase accumulator: frame start loads staged count and clears remainder
  always_comb begin
    n_eff    = frame_start ? pend_q : act_q;
    acc_base = frame_start ? '0 : acc_q;
    sum      = SUM_W'(acc_base) + SUM_W'(n_eff);
    carry    = (sum >= SLOTS_S);
    act_d    = act_q;
    acc_d    = acc_q;
    pulse_d  = pulse_q;
    if (tick) begin
      act_d   = n_eff;
      acc_d   = carry ? SLOT_W'(sum - SLOTS_S) : SLOT_W'(sum);
      pulse_d = carry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      act_q   <= '0;
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      act_q   <= act_d;
      acc_q   <= acc_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  // checker state: pulses emitted in the frame now running
  logic [CNT_W-1:0] tally_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tally_q <= '0;
    end else if (tick) begin
      tally_q <= frame_start ? CNT_W'(carry) : tally_q + CNT_W'(carry);
    end
  end

  // R2
  pulse_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (tally_q == act_q));

  // R5
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == '0) |=> !pulse_o);

  // R5
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q <= MAX_V) && (act_q <= MAX_V));

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_q));
endmodule

// File: rtl/fpc_phase_gen.sv
module fpc_phase_gen #(
  parameter int SLOTS  = fpc_pkg::FRAME_SLOTS,
  parameter int PHASES = fpc_pkg::PHASES_PER_FRAME,
  parameter int DEAD_W = fpc_pkg::DEAD_W,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DEAD_W-1:0] dead_len,
  output logic              phi1_o,
  output logic              phi2_o
);
  import fpc_pkg::*;

  localparam int HALF = SLOTS / (2 * PHASES);
  localparam logic [SLOT_W-1:0] HALF_V   = SLOT_W'(HALF);
  localparam logic [DEAD_W-1:0] DEAD_ONE = DEAD_W'(1);

  ph_state_e         st_q, st_d;
  logic [DEAD_W-1:0] dcnt_q, dcnt_d;
  logic              phi1_q, phi1_d;
  logic              phi2_q, phi2_d;
  logic              boundary;
  logic              second_half;

  always_comb begin
    boundary    = tick && ((slot % HALF_V) == '0);
    second_half = ((slot / HALF_V) & SLOT_W'(1)) != '0;
    st_d   = st_q;
    dcnt_d = dcnt_q;
    phi1_d = phi1_q;
    phi2_d = phi2_q;
    if (boundary) begin
      st_d   = second_half ? PH_TWO : PH_ONE;
      dcnt_d = dead_len - DEAD_ONE;
      phi1_d = 1'b0;
      phi2_d = 1'b0;
    end else if (dcnt_q != '0) begin
      dcnt_d = dcnt_q - DEAD_ONE;
      phi1_d = 1'b0;
      phi2_d = 1'b0;
    end else begin
      phi1_d = (st_q == PH_ONE);
      phi2_d = (st_q == PH_TWO);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      dcnt_q <= '0;
      phi1_q <= 1'b0;
      phi2_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      dcnt_q <= dcnt_d;
      phi1_q <= phi1_d;
      phi2_q <= phi2_d;
    end
  end

  assign phi1_o = phi1_q;
  assign phi2_o = phi2_q;

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi1_q && phi2_q));

  // R9
  boundary_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (!phi1_q && !phi2_q));
endmodule

// File: rtl/frame_pulse_clkgen.sv
module frame_pulse_clkgen #(
  parameter int NUM_LANES        = fpc_pkg::NUM_LANES,
  parameter int FRAME_SLOTS      = fpc_pkg::FRAME_SLOTS,
  parameter int CNT_W            = fpc_pkg::CNT_W,
  parameter int MAX_COUNT        = fpc_pkg::MAX_COUNT,
  parameter int PHASES_PER_FRAME = fpc_pkg::PHASES_PER_FRAME,
  parameter int DEAD_W           = fpc_pkg::DEAD_W
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               tick_en,
  input  logic                               cfg_we,
  input  logic [$clog2(NUM_LANES+1)-1:0]     cfg_sel,
  input  logic [CNT_W-1:0]                   cfg_data,
  output logic [NUM_LANES-1:0]               pulse_clk,
  output logic                               phi1,
  output logic                               phi2,
  output logic                               frame_strobe
);
  localparam int SEL_W  = $clog2(NUM_LANES + 1);
  localparam int SLOT_W = $clog2(FRAME_SLOTS);
  localparam logic [SEL_W-1:0]  SEL_DEAD = SEL_W'(NUM_LANES);
  localparam logic [DEAD_W-1:0] DEAD_MIN = DEAD_W'(1);

  logic              rst_sync_n;
  logic [SLOT_W-1:0] slot;
  logic              frame_start;
  logic [DEAD_W-1:0] dead_q, dead_d;
  logic [DEAD_W-1:0] dead_in;
  logic              dead_wr;

  fpc_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  fpc_slot_counter #(.SLOTS(FRAME_SLOTS), .SLOT_W(SLOT_W)) i_slot (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .tick          (tick_en),
    .slot_o        (slot),
    .frame_start_o (frame_start),
    .strobe_o      (frame_strobe)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic lane_wr;
    assign lane_wr = cfg_we && (cfg_sel == SEL_W'(g));
    fpc_pulse_lane #(
      .SLOTS     (FRAME_SLOTS),
      .CNT_W     (CNT_W),
      .MAX_COUNT (MAX_COUNT)
    ) i_lane (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .tick        (tick_en),
      .frame_start (frame_start),
      .wr_en       (lane_wr),
      .wr_cnt      (cfg_data),
      .pulse_o     (pulse_clk[g])
    );
  end

  // dead-time register, floored at one fast cycle
  always_comb begin
    dead_wr = cfg_we && (cfg_sel == SEL_DEAD);
    dead_in = cfg_data[DEAD_W-1:0];
    dead_d  = dead_q;
    if (dead_wr) begin
      dead_d = (dead_in == '0) ? DEAD_MIN : dead_in;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dead_q <= DEAD_MIN;
    end else begin
      dead_q <= dead_d;
    end
  end

  fpc_phase_gen #(
    .SLOTS  (FRAME_SLOTS),
    .PHASES (PHASES_PER_FRAME),
    .DEAD_W (DEAD_W),
    .SLOT_W (SLOT_W)
  ) i_phase (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick_en),
    .slot     (slot),
    .dead_len (dead_q),
    .phi1_o   (phi1),
    .phi2_o   (phi2)
  );

  // R9
  dead_floor_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dead_q != '0);
endmodule

// File: tb/test_frame_pulse_clkgen.sv
`timescale 1ns/1ps
module test_frame_pulse_clkgen;
  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic       cfg_we;
  logic [1:0] cfg_sel;
  logic [6:0] cfg_data;
  logic [2:0] pulse_clk;
  logic       phi1;
  logic       phi2;
  logic       frame_strobe;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  int cur [3];

  // lane counts {lane2, lane1, lane0} as written (before saturation)
  localparam int NVEC = 6;
  localparam logic [20:0] VEC [NVEC] = '{
    {7'd3,   7'd2,   7'd1},
    {7'd5,   7'd63,  7'd64},
    {7'd100, 7'd127, 7'd0},
    {7'd2,   7'd32,  7'd16},
    {7'd33,  7'd8,   7'd45},
    {7'd64,  7'd1,   7'd37}
  };

  frame_pulse_clkgen i_frame_pulse_clkgen (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_data     (cfg_data),
    .pulse_clk    (pulse_clk),
    .phi1         (phi1),
    .phi2         (phi2),
    .frame_strobe (frame_strobe)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // one sample tick every four fast cycles
  initial begin
    tick_en = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clamp_cnt(input int v);
    return (v > 64) ? 64 : v;
  endfunction

  function automatic bit exp_pulse(input int n, input int s);
    return ((s + 1) * n) / 128 > (s * n) / 128;
  endfunction

  function automatic bit is_pow2(input int n);
    return (n > 0) && ((n & (n - 1)) == 0);
  endfunction

  task automatic write_cfg(input int sel, input int data);
    cfg_we   = 1'b1;
    cfg_sel  = 2'(sel);
    cfg_data = 7'(data);
    @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  task automatic next_slot();
    do @(posedge clk); while (tick_en !== 1'b1);
    @(negedge clk);
  endtask

  task automatic align();
    int guard = 0;
    do begin
      next_slot();
      guard++;
    end while (frame_strobe !== 1'b1 && guard < 300);
  endtask

  task automatic check_frame(input string tag);
    int bad [3];
    int tally [3];
    int first_s [3];
    int bad_strobe;
    bad_strobe = 0;
    for (int l = 0; l < 3; l++) begin
      bad[l] = 0; tally[l] = 0; first_s[l] = -1;
    end
    align();
    for (int s = 0; s < 128; s++) begin
      if (s > 0) next_slot();
      if (frame_strobe !== (s == 0)) bad_strobe++;
      for (int l = 0; l < 3; l++) begin
        if (pulse_clk[l] === 1'b1) tally[l]++;
        if (pulse_clk[l] !== exp_pulse(cur[l], s)) begin
          bad[l]++;
          if (first_s[l] < 0) first_s[l] = s;
        end
      end
    end
    check(bad_strobe == 0, "R1", {tag, " strobe only in slot 0"}, bad_strobe, 0);
    for (int l = 0; l < 3; l++) begin
      check(bad[l] == 0, is_pow2(cur[l]) ? "R4" : "R2",
            $sformatf("%s lane%0d slot positions (first bad slot %0d)", tag, l, first_s[l]),
            bad[l], 0);
      check(tally[l] == cur[l], "R2", $sformatf("%s lane%0d pulses per frame", tag, l),
            tally[l], cur[l]);
    end
  endtask

  task automatic measure_phase(input int d_exp, input string tag);
    int low, r1, r2, ov;
    logic p1, p2;
    align();
    low = 0;
    while (phi1 !== 1'b1 && phi2 !== 1'b1 && low < 200) begin
      low++;
      @(negedge clk);
    end
    check(low == d_exp, "R9", {tag, " dead cycles before phi1"}, low, d_exp);
    check(phi1 === 1'b1, "R8", {tag, " phi1 rises first in frame"}, int'(phi1), 1);
    r1 = 1; r2 = 0; ov = 0;
    p1 = phi1; p2 = phi2;
    for (int k = low + 1; k < 512; k++) begin
      @(negedge clk);
      if (phi1 && !p1) r1++;
      if (phi2 && !p2) r2++;
      if (phi1 && phi2) ov++;
      p1 = phi1; p2 = phi2;
    end
    check(r1 == 4, "R8", {tag, " phi1 rises per frame"}, r1, 4);
    check(r2 == 4, "R8", {tag, " phi2 rises per frame"}, r2, 4);
    check(ov == 0, "R8", {tag, " overlap cycles"}, ov, 0);
  endtask

  task automatic check_quiet(input string tag);
    check(pulse_clk == 3'b000, "R10", {tag, " pulse_clk low"}, int'(pulse_clk), 0);
    check(!phi1 && !phi2, "R10", {tag, " phases low"}, int'({phi1, phi2}), 0);
    check(frame_strobe == 1'b0, "R10", {tag, " strobe low"}, int'(frame_strobe), 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_data = '0;
    for (int l = 0; l < 3; l++) cur[l] = 0;
    repeat (6) @(negedge clk);
    check_quiet("in reset");
    rst_n = 1'b1;

    // R5 R10: counts start at zero, outputs stay low
    check_frame("after reset (R5 R10)");

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      for (int l = 0; l < 3; l++) begin
        write_cfg(l, int'(VEC[v][7*l +: 7]));
        cur[l] = clamp_cnt(int'(VEC[v][7*l +: 7]));
      end
      align();
      check_frame($sformatf("vec%0d", v));
      if (v == 0) check_frame("vec0 repeat (R3)");
    end

    // R7 R6: mid-frame rewrite of lane 0 only
    begin
      int tally0, old0;
      old0 = cur[0];
      tally0 = 0;
      align();
      for (int s = 0; s < 128; s++) begin
        if (s > 0) next_slot();
        if (pulse_clk[0] === 1'b1) tally0++;
        if (s == 40) write_cfg(0, 3);
      end
      check(tally0 == old0, "R7", "frame holding mid-frame write keeps old count", tally0, old0);
      cur[0] = 3;
      check_frame("next frame after rewrite (R7 R6)");
    end

    // R8 R9: phase generator
    measure_phase(1, "default dead");
    write_cfg(3, 6);
    measure_phase(6, "dead=6");
    write_cfg(3, 0);
    measure_phase(1, "dead written 0");

    // R10: reset during operation clears counts
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_quiet("mid-run reset");
    rst_n = 1'b1;
    for (int l = 0; l < 3; l++) cur[l] = 0;
    check_frame("after mid-run reset (R10)");
    measure_phase(1, "dead back to 1 after reset (R10)");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule